// File: doc/BRIEF.md
# Framed CRC-16 Append and Check

This block guards a contactless tag's framed byte link with a 16-bit cyclic check. The block has two independent paths. On the receive path, each incoming byte carries a start flag and an end flag. The block runs the check over every byte of the frame, including the two check bytes at the tail. One cycle after the closing byte it pulses either "good" or "bad". Upper layers then act only on good frames, and a bad frame is dropped without any answer.

On the transmit path, payload bytes arrive over a valid/ready handshake, and the final payload byte carries a last flag. The block computes the check over the payload and appends the two check bytes itself. It sends everything out as a serial bit stream, one bit per clock. The least significant bit of each byte goes first, and the low check byte goes before the high one. Markers flag the first and the last bit of the serial frame.

The check uses the generator x^16 + x^12 + x^5 + 1 in reflected form (0x8408) with a right-shifting register, and it processes one byte per cycle. The register is preset to 0xFFFF at the start of each frame, and the value sent is the ones' complement of the final register.

Top module: `frame_crc16`

## Requirements
- R1: On receive, the check register is preset to 0xFFFF on every byte flagged as start and runs over all bytes of the frame. When the register equals 0xF0B8 after the end-flagged byte and the frame held at least 2 bytes, `rx_ok_o` pulses.
- R2: On receive, a frame of at least 2 bytes whose register differs from 0xF0B8 after the end-flagged byte pulses `rx_bad_o`, and `rx_ok_o` stays low.
- R3: `rx_ok_o` and `rx_bad_o` are single-cycle pulses. Exactly one of them rises in the cycle after an accepted end-flagged byte of an open frame, and neither rises at any other time.
- R4: A frame of a single byte (start and end flags set on the same byte) pulses `rx_bad_o`.
- R5: A start-flagged byte arriving while a frame is open abandons that frame without a pulse. A new frame then begins with that byte and a freshly preset register.
- R6: Bytes that arrive while no frame is open and carry no start flag are ignored, and they produce no pulse even when their end flag is set.
- R7: On transmit, the two check bytes follow the last payload byte directly. They are the ones' complement of the register run over the payload, low byte first. For the nine-byte ASCII payload "123456789" the check field is 0x906E, so 0x6E is sent first.
- R8: Each byte is sent on `ser_bit_o` least significant bit first, one bit per cycle while `ser_valid_o` is high. The first bit appears in the cycle after the byte is accepted. A byte accepted while the previous byte's final bit is out follows with no gap.
- R9: `ser_sof_o` is high only on the first bit of a serial frame, and `ser_eof_o` only on the last bit of the high check byte. `ser_valid_o` is low in the cycle after `ser_eof_o`.
- R10: `tx_ready_o` is high only when the serializer is empty or on its final bit and no check byte is pending or being sent. It is therefore low from the acceptance of the last payload byte until the frame's final bit has left.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | 1 | Receive byte present this cycle |
| rx_data_i | input | 8 | Receive byte |
| rx_sof_i | input | 1 | Byte is the first of a frame |
| rx_eof_i | input | 1 | Byte is the last of a frame (second check byte) |
| rx_ok_o | output | 1 | Pulse: frame check passed |
| rx_bad_o | output | 1 | Pulse: frame check failed or frame too short |
| tx_valid_i | input | 1 | Transmit payload byte offered |
| tx_data_i | input | 8 | Transmit payload byte |
| tx_last_i | input | 1 | Offered byte ends the payload |
| tx_ready_o | output | 1 | Transmit byte accepted when valid is also high |
| ser_bit_o | output | 1 | Serial data bit |
| ser_valid_o | output | 1 | Serial bit present |
| ser_sof_o | output | 1 | First bit of a serial frame |
| ser_eof_o | output | 1 | Last bit of a serial frame |

## Verification
The properties assume that a transmit byte is only counted as taken when `tx_ready_o` was high. They also assume that receive bytes arrive one per cycle, at most, with consistent flags, and the pulse checks rely on the fact that no frame can close in two consecutive cycles with a good result. The stimulus keeps within these limits: it holds `tx_valid_i` until the handshake completes, it changes inputs only mid-cycle, and it builds receive frames from well-formed start, body and end bytes. Its corrupted, truncated, aborted and stray-byte cases vary only the data and where the flags fall.

// File: rtl/frame_crc16_pkg.sv
package frame_crc16_pkg;
  localparam int          BYTE_W      = 8;
  localparam logic [15:0] CRC_POLY_R  = 16'h8408;
  localparam logic [15:0] CRC_PRESET  = 16'hFFFF;
  localparam logic [15:0] CRC_RESIDUE = 16'hF0B8;

  typedef enum logic [2:0] {
    TX_IDLE, TX_BODY, TX_CHK_LO, TX_CHK_HI, TX_DRAIN
  } tx_phase_e;

  // one byte through the reflected register, bit 0 first
  function automatic logic [15:0] crc16_step(input logic [15:0] crc,
                                             input logic [BYTE_W-1:0] d);
    logic [15:0] c;
    c = crc;
    for (int i = 0; i < BYTE_W; i++) begin
      if (c[0] ^ d[i]) c = (c >> 1) ^ CRC_POLY_R;
      else             c = c >> 1;
    end
    return c;
  endfunction
endpackage

// File: rtl/crc16_rx_check.sv
module crc16_rx_check
  import frame_crc16_pkg::*;
#(
  parameter int MIN_LEN = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              sof_i,
  input  logic              eof_i,
  output logic              ok_o,
  output logic              bad_o
);
  localparam int              LEN_W   = $clog2(MIN_LEN + 1);
  localparam logic [LEN_W-1:0] LEN_SAT = LEN_W'(MIN_LEN);

  logic              open_q, ok_q, bad_q;
  logic [15:0]       crc_q, crc_nxt;
  logic [LEN_W-1:0]  len_q, len_base, len_nxt;
  logic              take, pass;

  always_comb begin
    crc_nxt  = crc16_step(sof_i ? CRC_PRESET : crc_q, data_i);
    len_base = sof_i ? '0 : len_q;
    len_nxt  = (len_base == LEN_SAT) ? len_base : len_base + 1'b1;
    take     = valid_i && (sof_i || open_q);
    pass     = (len_nxt == LEN_SAT) && (crc_nxt == CRC_RESIDUE);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q <= 1'b0;
      crc_q  <= CRC_PRESET;
      len_q  <= '0;
      ok_q   <= 1'b0;
      bad_q  <= 1'b0;
    end else begin
      ok_q  <= take && eof_i && pass;
      bad_q <= take && eof_i && !pass;
      if (take) begin
        crc_q  <= crc_nxt;
        len_q  <= len_nxt;
        open_q <= !eof_i;
      end
    end
  end

  assign ok_o  = ok_q;
  assign bad_o = bad_q;
endmodule

// File: rtl/crc16_bit_shifter.sv
module crc16_bit_shifter #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  output logic         bit_o,
  output logic         valid_o,
  output logic         final_o,
  output logic         room_o
);
  localparam int CNT_W = $clog2(W + 1);

  logic [W-1:0]     sh_q;
  logic [CNT_W-1:0] left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      left_q <= '0;
    end else if (load_i) begin
      sh_q   <= data_i;
      left_q <= CNT_W'(W);
    end else if (left_q != '0) begin
      sh_q   <= sh_q >> 1;
      left_q <= left_q - 1'b1;
    end
  end

  assign bit_o   = sh_q[0];
  assign valid_o = left_q != '0;
  assign final_o = left_q == CNT_W'(1);
  assign room_o  = left_q <= CNT_W'(1);
endmodule

// File: rtl/crc16_tx_framer.sv
module crc16_tx_framer
  import frame_crc16_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              last_i,
  output logic              ready_o,
  output logic              ser_bit_o,
  output logic              ser_valid_o,
  output logic              ser_sof_o,
  output logic              ser_eof_o
);
  tx_phase_e         phase_q;
  logic [15:0]       crc_q, crc_nxt;
  logic              sof_q, room, fin, accept, load;
  logic [BYTE_W-1:0] ld_data;

  crc16_bit_shifter #(.W(BYTE_W)) i_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .data_i  (ld_data),
    .bit_o   (ser_bit_o),
    .valid_o (ser_valid_o),
    .final_o (fin),
    .room_o  (room)
  );

  assign ready_o = room && (phase_q == TX_IDLE || phase_q == TX_BODY);
  assign accept  = valid_i && ready_o;
  assign crc_nxt = crc16_step(phase_q == TX_IDLE ? CRC_PRESET : crc_q, data_i);

  always_comb begin
    load    = 1'b0;
    ld_data = data_i;
    unique case (phase_q)
      TX_IDLE, TX_BODY: load = accept;
      TX_CHK_LO: begin load = room; ld_data = ~crc_q[7:0];  end
      TX_CHK_HI: begin load = room; ld_data = ~crc_q[15:8]; end
      default:   load = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= TX_IDLE;
      crc_q   <= CRC_PRESET;
      sof_q   <= 1'b0;
    end else begin
      sof_q <= accept && (phase_q == TX_IDLE);
      unique case (phase_q)
        TX_IDLE, TX_BODY: if (accept) begin
          crc_q   <= crc_nxt;
          phase_q <= last_i ? TX_CHK_LO : TX_BODY;
        end
        TX_CHK_LO: if (room) phase_q <= TX_CHK_HI;
        TX_CHK_HI: if (room) phase_q <= TX_DRAIN;
        TX_DRAIN:  if (fin)  phase_q <= TX_IDLE;
        default:   phase_q <= TX_IDLE;
      endcase
    end
  end

  assign ser_sof_o = sof_q;
  assign ser_eof_o = (phase_q == TX_DRAIN) && fin;
endmodule

// File: rtl/frame_crc16.sv
module frame_crc16
  import frame_crc16_pkg::*;
#(
  parameter int MIN_LEN = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_valid_i,
  input  logic [BYTE_W-1:0] rx_data_i,
  input  logic              rx_sof_i,
  input  logic              rx_eof_i,
  output logic              rx_ok_o,
  output logic              rx_bad_o,
  input  logic              tx_valid_i,
  input  logic [BYTE_W-1:0] tx_data_i,
  input  logic              tx_last_i,
  output logic              tx_ready_o,
  output logic              ser_bit_o,
  output logic              ser_valid_o,
  output logic              ser_sof_o,
  output logic              ser_eof_o
);
  crc16_rx_check #(.MIN_LEN(MIN_LEN)) i_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (rx_valid_i),
    .data_i  (rx_data_i),
    .sof_i   (rx_sof_i),
    .eof_i   (rx_eof_i),
    .ok_o    (rx_ok_o),
    .bad_o   (rx_bad_o)
  );

  crc16_tx_framer i_tx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .valid_i     (tx_valid_i),
    .data_i      (tx_data_i),
    .last_i      (tx_last_i),
    .ready_o     (tx_ready_o),
    .ser_bit_o   (ser_bit_o),
    .ser_valid_o (ser_valid_o),
    .ser_sof_o   (ser_sof_o),
    .ser_eof_o   (ser_eof_o)
  );
endmodule

// File: rtl/frame_crc16_chk.sv
module frame_crc16_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic rx_valid_i,
  input logic rx_sof_i,
  input logic rx_eof_i,
  input logic rx_ok_o,
  input logic rx_bad_o,
  input logic tx_ready_o,
  input logic ser_valid_o,
  input logic ser_sof_o,
  input logic ser_eof_o
);
  p_result_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rx_ok_o, rx_bad_o}));

  p_result_after_eof_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_ok_o || rx_bad_o) |-> $past(rx_valid_i && rx_eof_i));

  p_ok_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_ok_o |=> !rx_ok_o);

  p_short_frame_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && rx_sof_i && rx_eof_i) |=> rx_bad_o);

  p_stream_cont_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ser_valid_o && !ser_eof_o && !tx_ready_o) |=> ser_valid_o);

  p_sof_valid_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ser_sof_o |-> ser_valid_o);

  p_eof_end_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ser_eof_o |=> !ser_valid_o);

  p_eof_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ser_eof_o |-> (ser_valid_o && !tx_ready_o));
endmodule

bind frame_crc16 frame_crc16_chk i_chk (.*);

// File: tb/test_frame_crc16.sv
module test_frame_crc16;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rx_valid_i = 1'b0, rx_sof_i = 1'b0, rx_eof_i = 1'b0;
  logic [7:0] rx_data_i = '0;
  logic       tx_valid_i = 1'b0, tx_last_i = 1'b0;
  logic [7:0] tx_data_i = '0;
  logic       rx_ok_o, rx_bad_o, tx_ready_o, ser_bit_o, ser_valid_o, ser_sof_o, ser_eof_o;

  frame_crc16 i_frame_crc16 (.*);

  always #5 clk_i = ~clk_i;

  int n_checks = 0, n_fail = 0;
  string rx_req = "R1";

  // receive model
  logic [7:0] rx_q[$];
  bit m_open = 0, exp_ok = 0, exp_bad = 0;
  // transmit model
  logic [7:0] tx_frame[$];
  bit exp_bits[$], exp_sof[$], exp_eof[$], exp_chk[$];
  bit tx_open = 0, acc = 0, cap_on = 0;
  int chk_pend = 0;
  logic [15:0] cap = '0;

  // check value in plain (non-reflected) form on LSB-first bits, then mirrored
  function automatic logic [15:0] ref_crc(input logic [7:0] q[$], input int n);
    logic [15:0] r = 16'hFFFF, m;
    for (int k = 0; k < n; k++)
      for (int i = 0; i < 8; i++) begin
        bit fb = r[15] ^ q[k][i];
        r = {r[14:0], 1'b0};
        if (fb) r = r ^ 16'h1021;
      end
    for (int i = 0; i < 16; i++) m[i] = r[15-i];
    return m;
  endfunction

  task automatic fail(input string req, input string what, input int act, input int exp);
    n_fail++;
    $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
  endtask

  task automatic compare();
    bit b, s, e, c;
    n_checks++;
    if (rx_ok_o !== exp_ok || rx_bad_o !== exp_bad)
      fail(rx_req, "rx ok/bad", {rx_ok_o, rx_bad_o}, {exp_ok, exp_bad});
    n_checks++;
    if (tx_ready_o !== ((exp_bits.size() <= 1) && chk_pend == 0))
      fail("R10", "tx_ready", tx_ready_o, (exp_bits.size() <= 1) && chk_pend == 0);
    n_checks++;
    if (exp_bits.size() > 0) begin
      b = exp_bits.pop_front(); s = exp_sof.pop_front();
      e = exp_eof.pop_front();  c = exp_chk.pop_front();
      if (c) chk_pend--;
      if ({ser_valid_o, ser_bit_o, ser_sof_o, ser_eof_o} !== {1'b1, b, s, e})
        fail(e ? "R9" : "R8", "serial v/bit/sof/eof",
             {ser_valid_o, ser_bit_o, ser_sof_o, ser_eof_o}, {1'b1, b, s, e});
      cap = {ser_bit_o, cap[15:1]};
      if (e && cap_on) begin
        n_checks++;
        if (cap !== 16'h906E) fail("R7", "check field of 123456789", cap, 16'h906E);
        cap_on = 0;
      end
    end else if ({ser_valid_o, ser_sof_o, ser_eof_o} !== 3'b000)
      fail("R9", "serial idle", {ser_valid_o, ser_sof_o, ser_eof_o}, 0);
  endtask

  task automatic push_byte(input logic [7:0] d, input bit first, input bit chk, input bit final_b);
    for (int i = 0; i < 8; i++) begin
      exp_bits.push_back(d[i]);
      exp_sof.push_back(first && i == 0);
      exp_eof.push_back(final_b && i == 7);
      exp_chk.push_back(chk);
    end
    if (chk) chk_pend += 8;
  endtask

  task automatic model_update();
    logic [15:0] c;
    exp_ok = 0; exp_bad = 0;
    if (rx_valid_i) begin
      if (rx_sof_i) begin rx_q = {}; m_open = 1; end
      if (m_open) begin
        rx_q.push_back(rx_data_i);
        if (rx_eof_i) begin
          m_open = 0;
          if (rx_q.size() >= 2) begin
            c = ~ref_crc(rx_q, rx_q.size() - 2);
            exp_ok = (c[7:0] == rx_q[rx_q.size()-2]) && (c[15:8] == rx_q[rx_q.size()-1]);
            exp_bad = !exp_ok;
          end else exp_bad = 1;
        end
      end
    end
    acc = tx_valid_i && tx_ready_o;
    if (acc) begin
      bit first = !tx_open;
      if (first) begin tx_frame = {}; tx_open = 1; end
      tx_frame.push_back(tx_data_i);
      push_byte(tx_data_i, first, 0, 0);
      if (tx_last_i) begin
        c = ~ref_crc(tx_frame, tx_frame.size());
        push_byte(c[7:0], 0, 1, 0);
        push_byte(c[15:8], 0, 1, 1);
        tx_open = 0;
      end
    end
  endtask

  task automatic tick(); @(negedge clk_i); compare(); endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      tick(); rx_valid_i = 0; tx_valid_i = 0; model_update();
    end
  endtask

  task automatic rx_byte(input logic [7:0] d, input bit s, input bit e);
    tick();
    rx_valid_i = 1; rx_data_i = d; rx_sof_i = s; rx_eof_i = e; tx_valid_i = 0;
    model_update();
  endtask

  task automatic tx_byte(input logic [7:0] d, input bit last);
    do begin
      tick();
      rx_valid_i = 0; tx_valid_i = 1; tx_data_i = d; tx_last_i = last;
      model_update();
    end while (!acc);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  // good receive frame: payload, then complemented check low byte first
  task automatic rx_frame(input logic [7:0] p[$], input bit corrupt);
    logic [15:0] c = ~ref_crc(p, p.size());
    for (int i = 0; i < p.size(); i++) rx_byte(p[i], i == 0, 0);
    rx_byte(c[7:0] ^ {7'd0, corrupt}, p.size() == 0, 0);
    rx_byte(c[15:8], 0, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    fail("R8", "watchdog cycles", 200000, 0);
    summary();
    $finish;
  end

  initial begin
    logic [7:0] digits[$] = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
    logic [7:0] empty[$] = {};
    repeat (3) begin
      @(negedge clk_i);
      n_checks++;
      if ({rx_ok_o, rx_bad_o, tx_ready_o, ser_valid_o, ser_sof_o, ser_eof_o} !== 6'b001000)
        fail("R3", "reset outputs",
             {rx_ok_o, rx_bad_o, tx_ready_o, ser_valid_o, ser_sof_o, ser_eof_o}, 6'b001000);
    end
    rst_ni = 1;
    idle(2);

    // R1: known nine-byte frame with 0x6E, 0x90 check bytes
    rx_req = "R1";
    for (int i = 0; i < 9; i++) rx_byte(digits[i], i == 0, 0);
    rx_byte(8'h6E, 0, 0); rx_byte(8'h90, 0, 1);
    idle(1);
    rx_frame('{8'hA5, 8'h00, 8'hFF}, 0);  // back-to-back with next
    rx_frame('{8'h01}, 0);
    rx_frame(empty, 0);                     // two check bytes only
    idle(2);
    // R2: corrupted check
    rx_req = "R2";
    rx_frame('{8'h10, 8'h20, 8'h30}, 1);
    for (int i = 0; i < 9; i++) rx_byte(digits[i], i == 0, 0);
    rx_byte(8'h90, 0, 0); rx_byte(8'h6E, 0, 1);  // swapped order
    idle(2);
    // R4: single-byte frames
    rx_req = "R4";
    rx_byte(8'h00, 1, 1);
    rx_byte(8'hFF, 1, 1);
    idle(2);
    // R5: restart mid-frame
    rx_req = "R5";
    rx_byte(8'h55, 1, 0); rx_byte(8'h66, 0, 0);
    rx_frame('{8'h12, 8'h34}, 0);
    rx_byte(8'h77, 1, 0);
    rx_frame('{8'h9A}, 1);
    idle(2);
    // R6: stray bytes outside a frame
    rx_req = "R6";
    rx_byte(8'h6E, 0, 0); rx_byte(8'h90, 0, 1); rx_byte(8'h00, 0, 1);
    idle(2);
    rx_req = "R3";
    idle(1);

    // R7/R8/R9/R10: transmit, continuous
    cap_on = 1;
    for (int i = 0; i < 9; i++) tx_byte(digits[i], i == 8);
    idle(30);
    // transmit with gaps and a one-byte payload
    tx_byte(8'hC3, 0); idle(3); tx_byte(8'h5A, 1);
    tx_byte(8'h01, 1);   // offered while check bytes pend: must wait
    idle(30);
    for (int i = 0; i < 4; i++) tx_byte(8'(i * 37), i == 3);
    idle(40);

    summary();
    $finish;
  end
endmodule